// File: doc/BRIEF.md
# Banked CPU General-Purpose Register File

This block holds the general-purpose registers of a 32-bit CISC-style processor core. There are eight data registers and eight address registers. The highest address register is the stack pointer, and it is backed by two physical registers: one used in user state and one used in supervisor state. The core reads two operands per cycle through combinational read ports and writes back one result per clock edge. Each write carries a size qualifier, and the size decides how the new value is combined with the old contents of the register.

Data and address registers take sized writes differently. A narrow write to a data register changes only the low bits and leaves the rest as they were. A word write to an address register is sign-extended across all 32 bits. A byte write to an address register has no legal meaning, so the block drops it and raises an error pulse. A separate side port lets privileged code read and write the user-state stack pointer while the core runs in supervisor state.

Top module: `cpu_gpr_file`

## Requirements
- R1: While `rst_n` is low, and after it rises, every physical register reads as zero until it is written. This includes both stack-pointer copies.
- R2: Size codes on `wr_size` are 00 byte, 01 word, 10 long and 11 reserved. A byte write to a data register (index 0 to 7) replaces bits 7:0 and keeps bits 31:8.
- R3: A word write to a data register replaces bits 15:0 and keeps bits 31:16.
- R4: A long write to any register replaces all 32 bits.
- R5: A word write to an address register (index 8 to 15) stores bits 15:0 of the data with bit 15 copied into bits 31:16.
- R6: A byte write to an address register leaves every register unchanged. It drives `wr_err` high for exactly the one cycle that follows the write edge.
- R7: A write with the reserved size code 11 leaves every register unchanged and drives `wr_err` high for the one cycle that follows.
- R8: Index 15 on any read or write port refers to the supervisor stack pointer when `sup_mode` is 1 and to the user stack pointer when it is 0. The two copies are independent.
- R9: When `sup_mode` is 1, `usp_rd_data` shows the user stack pointer and `usp_wr_en` long-writes it. When `sup_mode` is 0, `usp_rd_data` is zero and `usp_wr_en` has no effect.
- R10: When a read port selects the register that is being written in the same cycle, the read returns the value from before that write.
- R11: The two read ports select registers independently. A register that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes take effect on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode | input | 1 | 1 when the core is in supervisor state; selects the stack-pointer copy |
| rd_a_idx | input | 4 | Read port A index: 0-7 data registers, 8-15 address registers |
| rd_a_data | output | 32 | Read port A value (combinational) |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B value (combinational) |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write index |
| wr_size | input | 2 | Write size: 00 byte, 01 word, 10 long, 11 reserved |
| wr_data | input | 32 | Write value |
| wr_err | output | 1 | One-cycle pulse after an illegal write was dropped |
| usp_wr_en | input | 1 | Side-port write of the user stack pointer (honoured only in supervisor state) |
| usp_wr_data | input | 32 | Side-port write value |
| usp_rd_data | output | 32 | User stack pointer in supervisor state, zero otherwise |

## Verification
The merge properties assume that the read index is held on the cycle after a write, so that the register just written can be compared with its previous read value. The sign-extension property also assumes that `sup_mode` does not change across that cycle. The stimulus changes inputs only one nanosecond after each rising edge and always reads back the written register on the cycle that follows. It keeps `sup_mode` steady around writes to index 15, except in the cases that deliberately test the switch between stack-pointer copies.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } wsize_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
endpackage

// File: rtl/gpr_index_map.sv
// Maps an architectural register index and the privilege state to a
// physical slot: data regs first, then the unbanked address regs, then
// the user and supervisor copies of the top address register.
module gpr_index_map #(
    parameter int NCLS   = 8,
    parameter int IDX_W  = 4,
    parameter int PIDX_W = 5
) (
    input  logic [IDX_W-1:0]  arch_idx,
    input  logic              sup,
    output logic [PIDX_W-1:0] phys_idx
);
    localparam int USP_SLOT = 2*NCLS - 1;
    localparam int SSP_SLOT = 2*NCLS;

    logic is_sp;

    always_comb begin
        is_sp = (int'(arch_idx) == USP_SLOT);
        if (is_sp) begin
            phys_idx = sup ? PIDX_W'(SSP_SLOT) : PIDX_W'(USP_SLOT);
        end else begin
            phys_idx = PIDX_W'(arch_idx);
        end
    end
endmodule

// File: rtl/gpr_write_merge.sv
// Combines a sized write with the old register value according to the
// register class; flags combinations that have no legal meaning.
module gpr_write_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      size,
    input  logic            is_addr,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_val,
    output logic [XLEN-1:0] merged,
    output logic            legal
);
    wsize_e sz;

    always_comb begin
        sz     = wsize_e'(size);
        merged = old_val;
        legal  = 1'b1;
        unique case (sz)
            SZ_BYTE: begin
                if (is_addr) begin
                    legal = 1'b0;
                end else begin
                    merged = {old_val[XLEN-1:BYTE_W], new_val[BYTE_W-1:0]};
                end
            end
            SZ_WORD: begin
                if (is_addr) begin
                    merged = {{(XLEN-HALF_W){new_val[HALF_W-1]}}, new_val[HALF_W-1:0]};
                end else begin
                    merged = {old_val[XLEN-1:HALF_W], new_val[HALF_W-1:0]};
                end
            end
            SZ_LONG: merged = new_val;
            SZ_RSVD: legal  = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpr_storage.sv
// Physical register array: one main write port, one user-SP side write
// port, two operand read ports, one old-value read port for merging.
module gpr_storage #(
    parameter int XLEN     = 32,
    parameter int NPHYS    = 17,
    parameter int PIDX_W   = 5,
    parameter int USP_SLOT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PIDX_W-1:0] w_idx,
    input  logic [XLEN-1:0]   w_val,
    input  logic              usp_we,
    input  logic [XLEN-1:0]   usp_val,
    input  logic [PIDX_W-1:0] ra_idx,
    output logic [XLEN-1:0]   ra_val,
    input  logic [PIDX_W-1:0] rb_idx,
    output logic [XLEN-1:0]   rb_val,
    input  logic [PIDX_W-1:0] ro_idx,
    output logic [XLEN-1:0]   ro_val,
    output logic [XLEN-1:0]   usp_q
);
    logic [XLEN-1:0] regs_q [NPHYS];

    for (genvar g = 0; g < NPHYS; g++) begin : g_reg
        logic hit_main;
        logic hit_side;
        assign hit_main = we && (int'(w_idx) == g);
        if (g == USP_SLOT) begin : g_usp
            assign hit_side = usp_we;
        end else begin : g_plain
            assign hit_side = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (hit_main) begin
                regs_q[g] <= w_val;
            end else if (hit_side) begin
                regs_q[g] <= usp_val;
            end
        end
    end

    always_comb begin
        ra_val = (int'(ra_idx) < NPHYS) ? regs_q[ra_idx] : '0;
        rb_val = (int'(rb_idx) < NPHYS) ? regs_q[rb_idx] : '0;
        ro_val = (int'(ro_idx) < NPHYS) ? regs_q[ro_idx] : '0;
        usp_q  = regs_q[USP_SLOT];
    end
endmodule

// File: rtl/cpu_gpr_file.sv
module cpu_gpr_file
    import gpr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NCLS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sup_mode,
    input  logic [$clog2(2*NCLS)-1:0]    rd_a_idx,
    output logic [XLEN-1:0]              rd_a_data,
    input  logic [$clog2(2*NCLS)-1:0]    rd_b_idx,
    output logic [XLEN-1:0]              rd_b_data,
    input  logic                         wr_en,
    input  logic [$clog2(2*NCLS)-1:0]    wr_idx,
    input  logic [1:0]                   wr_size,
    input  logic [XLEN-1:0]              wr_data,
    output logic                         wr_err,
    input  logic                         usp_wr_en,
    input  logic [XLEN-1:0]              usp_wr_data,
    output logic [XLEN-1:0]              usp_rd_data
);
    localparam int IDX_W    = $clog2(2*NCLS);
    localparam int NPHYS    = 2*NCLS + 1;
    localparam int PIDX_W   = $clog2(NPHYS);
    localparam int USP_SLOT = 2*NCLS - 1;

    logic [PIDX_W-1:0] pa, pb, pw;
    logic [XLEN-1:0]   old_val, merged, usp_q;
    logic              legal, commit, usp_commit, err_d;

    gpr_index_map #(.NCLS(NCLS), .IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_a (
        .arch_idx(rd_a_idx), .sup(sup_mode), .phys_idx(pa));
    gpr_index_map #(.NCLS(NCLS), .IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_b (
        .arch_idx(rd_b_idx), .sup(sup_mode), .phys_idx(pb));
    gpr_index_map #(.NCLS(NCLS), .IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_map_w (
        .arch_idx(wr_idx), .sup(sup_mode), .phys_idx(pw));

    gpr_write_merge #(.XLEN(XLEN)) u_merge (
        .size(wr_size), .is_addr(wr_idx[IDX_W-1]), .old_val(old_val),
        .new_val(wr_data), .merged(merged), .legal(legal));

    // Side port only acts in supervisor state, where index 15 on the main
    // port targets the supervisor copy, so the two ports never collide.
    assign commit     = wr_en && legal;
    assign usp_commit = usp_wr_en && sup_mode;
    assign err_d      = wr_en && !legal;

    gpr_storage #(.XLEN(XLEN), .NPHYS(NPHYS), .PIDX_W(PIDX_W), .USP_SLOT(USP_SLOT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(commit), .w_idx(pw), .w_val(merged),
        .usp_we(usp_commit), .usp_val(usp_wr_data),
        .ra_idx(pa), .ra_val(rd_a_data),
        .rb_idx(pb), .rb_val(rd_b_data),
        .ro_idx(pw), .ro_val(old_val),
        .usp_q(usp_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= err_d;
        end
    end

    always_comb begin
        usp_rd_data = sup_mode ? usp_q : '0;
    end
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
    import gpr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NCLS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sup_mode,
    input logic [$clog2(2*NCLS)-1:0] rd_a_idx,
    input logic [XLEN-1:0]           rd_a_data,
    input logic [$clog2(2*NCLS)-1:0] rd_b_idx,
    input logic [XLEN-1:0]           rd_b_data,
    input logic                      wr_en,
    input logic [$clog2(2*NCLS)-1:0] wr_idx,
    input logic [1:0]                wr_size,
    input logic [XLEN-1:0]           wr_data,
    input logic                      wr_err,
    input logic                      usp_wr_en,
    input logic [XLEN-1:0]           usp_wr_data,
    input logic [XLEN-1:0]           usp_rd_data
);
    localparam int IDX_W = $clog2(2*NCLS);

    a_r2_byte_merge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_size == SZ_BYTE && !wr_idx[IDX_W-1] && rd_a_idx == wr_idx
        |=> rd_a_idx != $past(wr_idx)
            || rd_a_data == {$past(rd_a_data[XLEN-1:8]), $past(wr_data[7:0])});

    a_r3_word_merge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_size == SZ_WORD && !wr_idx[IDX_W-1] && rd_a_idx == wr_idx
        |=> rd_a_idx != $past(wr_idx)
            || rd_a_data == {$past(rd_a_data[XLEN-1:16]), $past(wr_data[15:0])});

    a_r5_addr_sext: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_size == SZ_WORD && wr_idx[IDX_W-1]
        |=> rd_a_idx != $past(wr_idx) || sup_mode != $past(sup_mode)
            || rd_a_data == {{(XLEN-16){$past(wr_data[15])}}, $past(wr_data[15:0])});

    a_r6_addr_byte_err: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_size == SZ_BYTE && wr_idx[IDX_W-1] |=> wr_err);

    a_r7_rsvd_err: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_size == SZ_RSVD |=> wr_err);

    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en && (wr_size == SZ_RSVD
                                   || (wr_size == SZ_BYTE && wr_idx[IDX_W-1]))));

    a_r9_usp_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_mode |-> usp_rd_data == '0);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !usp_wr_en
        |=> rd_a_idx != $past(rd_a_idx) || sup_mode != $past(sup_mode)
            || rd_a_data == $past(rd_a_data));
endmodule

bind cpu_gpr_file gpr_file_chk #(.XLEN(XLEN), .NCLS(NCLS)) u_chk (.*);

// File: tb/test_cpu_gpr_file.sv
module test_cpu_gpr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_mode = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, usp_wr_data = '0, usp_rd_data;
    logic        wr_en = 1'b0, usp_wr_en = 1'b0, wr_err;
    logic [1:0]  wr_size = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cpu_gpr_file i_cpu_gpr_file (.*);

    typedef struct {
        logic [31:0] ea, eb, eu;
        logic        ee;
        string       tag, etag;
    } item_t;

    item_t       sb[$];
    logic [31:0] m [17];
    logic        pend_err = 1'b0;
    string       pend_tag = "R6/R7";
    bit          done = 1'b0;

    function automatic int phys(logic [3:0] i, bit s);
        if (i == 4'd15) return s ? 16 : 15;
        return int'(i);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit we, logic [3:0] wi, logic [1:0] ws,
                        logic [31:0] wd, bit sup, logic [3:0] ra, logic [3:0] rb,
                        bit uwe = 0, logic [31:0] ud = '0);
        item_t it;
        bit    addr, ok;
        int    p;
        @(posedge clk);
        #1;
        wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd; sup_mode = sup;
        rd_a_idx = ra; rd_b_idx = rb; usp_wr_en = uwe; usp_wr_data = ud;
        it.ea = m[phys(ra, sup)];
        it.eb = m[phys(rb, sup)];
        it.eu = sup ? m[15] : 32'h0;
        it.ee = pend_err;
        it.tag = tag;
        it.etag = pend_tag;
        sb.push_back(it);
        addr = wi[3];
        ok = we && (ws != 2'b11) && !(addr && ws == 2'b00);
        pend_err = we && !ok;
        pend_tag = tag;
        p = phys(wi, sup);
        if (ok) begin
            case (ws)
                2'b00: m[p] = {m[p][31:8], wd[7:0]};
                2'b01: m[p] = addr ? {{16{wd[15]}}, wd[15:0]} : {m[p][31:16], wd[15:0]};
                default: m[p] = wd;
            endcase
        end
        if (uwe && sup) m[15] = ud;
    endtask

    task automatic rd(string tag, bit sup, logic [3:0] ra, logic [3:0] rb);
        step(tag, 0, 0, 0, 0, sup, ra, rb);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.tag, rd_a_data, it.ea, "rd_a_data");
                chk(it.tag, rd_b_data, it.eb, "rd_b_data");
                chk(it.tag, usp_rd_data, it.eu, "usp_rd_data");
                chk(it.etag, {31'b0, wr_err}, {31'b0, it.ee}, "wr_err");
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 17; i++) m[i] = '0;
        // R1: all registers zero while in reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1", rd_a_data, 32'h0, "rd_a_data in reset");
        chk("R1", {31'b0, wr_err}, 32'h0, "wr_err in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) rd("R1", 0, 4'(i), 4'(15 - i));
        rd("R1", 1, 4'd15, 4'd0);

        // R4: long writes to data and address registers
        step("R4", 1, 4'd3, 2'b10, 32'h12345678, 0, 4'd3, 4'd10);
        step("R4", 1, 4'd10, 2'b10, 32'h80000001, 0, 4'd3, 4'd10);
        rd("R4", 0, 4'd10, 4'd3);
        // R2: byte merge on data register
        step("R2", 1, 4'd3, 2'b00, 32'hAABBCCDD, 0, 4'd3, 4'd3);
        rd("R2", 0, 4'd3, 4'd10);
        // R3: word merge on data register
        step("R3", 1, 4'd3, 2'b01, 32'h1111BEEF, 0, 4'd3, 4'd0);
        rd("R3", 0, 4'd3, 4'd0);
        // R5: word writes to address registers sign-extend
        step("R5", 1, 4'd10, 2'b01, 32'h00008001, 0, 4'd10, 4'd3);
        rd("R5", 0, 4'd10, 4'd3);
        step("R5", 1, 4'd9, 2'b01, 32'hFFFF7FFF, 0, 4'd9, 4'd10);
        rd("R5", 0, 4'd9, 4'd10);
        // R6: byte to address register dropped, error pulse
        step("R6", 1, 4'd10, 2'b00, 32'h000000AA, 0, 4'd10, 4'd9);
        rd("R6", 0, 4'd10, 4'd9);
        rd("R6", 0, 4'd10, 4'd9);
        // R7: reserved size dropped, error pulse
        step("R7", 1, 4'd3, 2'b11, 32'hDEADBEEF, 0, 4'd3, 4'd3);
        rd("R7", 0, 4'd3, 4'd0);
        rd("R7", 0, 4'd3, 4'd0);
        // R8: index 15 banked by supervisor state
        step("R8", 1, 4'd15, 2'b10, 32'h00001000, 0, 4'd15, 4'd15);
        rd("R8", 0, 4'd15, 4'd14);
        step("R8", 1, 4'd15, 2'b10, 32'h00002000, 1, 4'd15, 4'd15);
        rd("R8", 1, 4'd15, 4'd15);
        rd("R8", 0, 4'd15, 4'd15);
        step("R8", 1, 4'd15, 2'b01, 32'h0000F00D, 1, 4'd15, 4'd15);
        rd("R8", 1, 4'd15, 4'd15);
        rd("R8", 0, 4'd15, 4'd15);
        // R9: user-SP side port
        rd("R9", 1, 4'd15, 4'd0);
        step("R9", 0, 0, 0, 0, 1, 4'd15, 4'd0, 1, 32'h00003000);
        rd("R9", 0, 4'd15, 4'd15);
        rd("R9", 1, 4'd15, 4'd15);
        step("R9", 0, 0, 0, 0, 0, 4'd15, 4'd15, 1, 32'h0BADF00D);
        rd("R9", 0, 4'd15, 4'd0);
        rd("R9", 1, 4'd15, 4'd0);
        // R10: same-cycle read returns old value
        step("R10", 1, 4'd5, 2'b10, 32'hCAFEF00D, 0, 4'd5, 4'd5);
        rd("R10", 0, 4'd5, 4'd5);
        step("R10", 1, 4'd12, 2'b10, 32'h01020304, 0, 4'd12, 4'd5);
        rd("R10", 0, 4'd12, 4'd5);
        // R11: independent ports, idle hold
        for (int i = 0; i < 16; i++) rd("R11", i[0], 4'(i), 4'(i ^ 5));
        rd("R11", 0, 4'd3, 4'd10);

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule